// File: doc/BRIEF.md
# March-Algorithm Memory Self-Test Engine

This block tests a single-port synchronous SRAM from inside the chip. Once started, it issues one memory operation per clock: an address, a write strobe and a solid data background of all zeros or all ones. Each read is checked against the value the algorithm expects, using an on-board comparator. Nothing has to be supplied from outside apart from the start pulse and a mode bit.

Two algorithms are available. The scan mode makes four ascending passes over the memory: it writes zeros, reads them back, writes ones, and reads those back. The march mode runs six elements. In each middle element, a read and a write at the same address occupy two consecutive cycles. The address direction reverses for elements 3 and 4.

The scan mode finds cells that are stuck at a value. The march mode also finds cells that fail to make a transition, and cells that one neighbour disturbs. The first mismatch is logged and the run still goes on to its end, where a one-cycle done pulse carries the pass verdict.

Top module: `march_bist`

## Requirements
- R1: While reset is held, and after its release, busy, doneP, memEn, memWe, passOk and failSticky are all 0.
- R2: With modeSel=0 when the start is accepted, the block performs 4*DEPTH operations, one per cycle, in four passes. Every pass runs from address 0 upward. Pass 0 writes all zeros, pass 1 reads and expects zeros, pass 2 writes all ones, and pass 3 reads and expects ones.
- R3: With modeSel=1 when the start is accepted, the block runs six elements, indexed 0 to 5, for 10*DEPTH operations. Element 0 writes zeros, ascending. Elements 1 to 4 each issue a read and then, in the next cycle, a write to the same address. Their read/write values are 0/1, 1/0, 0/1 and 1/0. Elements 1 and 2 ascend, and elements 3 and 4 descend from DEPTH-1 down to 0. Element 5 reads and expects zeros, ascending.
- R4: memWe is high only together with memEn, and memWdata is always all zeros or all ones.
- R5: The comparator checks memRdata in the cycle after each read strobe, against the expected value of that read. Any mismatch makes the run fail.
- R6: On the first mismatch of a run, the block latches failAddr, failElem (the element or pass index as numbered in R2/R3) and failData (the word read) and sets failSticky. Later mismatches change none of these. All four are cleared when the next start is accepted.
- R7: A run keeps going after a failure. busy stays high for N+1 cycles, where N=10*DEPTH in march mode and N=4*DEPTH in scan mode. Then doneP is high for exactly one cycle with busy low. At that point passOk is 1 if and only if the run saw no mismatch, and passOk holds until the next accepted start.
- R8: startReq and modeSel have no effect while busy is high.
- R9: A cell bit that cannot fall from 1 to 0 once it has been written passes the scan mode. The march mode reports it at element 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a run when the block is idle |
| modeSel | input | 1 | 0 = scan test, 1 = march test; sampled at start |
| busy | output | 1 | A run is in progress |
| doneP | output | 1 | One-cycle end-of-run pulse |
| passOk | output | 1 | Verdict of the last run |
| failSticky | output | 1 | A mismatch occurred in the current or last run |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failElem | output | 3 | Element/pass index of the first mismatch |
| failData | output | DATA_W | Data read at the first mismatch |
| memEn | output | 1 | SRAM access strobe |
| memWe | output | 1 | SRAM write strobe |
| memAddr | output | ADDR_W | SRAM address |
| memWdata | output | DATA_W | SRAM write data |
| memRdata | input | DATA_W | SRAM read data, one cycle after a read |

## Verification
The assertions check the following on every cycle:
- a write strobe only ever comes with an access strobe;
- write data is always a solid background;
- memory operations happen only during a run;
- the done pulse lasts one cycle, arrives with busy low, and carries a verdict that agrees with the sticky flag;
- the fail log does not move during a run once it has been set.

Some behaviour only the bench scenarios can show, because a reference SRAM model with injected faults has to run against the block. This covers the exact operation order and direction of each element and the run length. It also covers where the first failure lands for stuck-at, no-fall and coupling faults, and the fact that the scan mode misses the no-fall cell while the march mode catches it.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  localparam int ELEM_W = 3;

  // Per-element behaviour of the active algorithm
  typedef struct packed {
    logic rd;      // element reads each address
    logic wr;      // element writes each address
    logic expOne;  // expected read background
    logic wrOne;   // write background
    logic down;    // descending address order
    logic last;    // final element of the algorithm
  } elemDesc_t;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic wrOne;
    logic expOne;
    logic clearLog;
    logic finish;
  } strobe_t;

  function automatic elemDesc_t lookupElem(input logic marchMode, input logic [ELEM_W-1:0] idx);
    elemDesc_t d;
    d = '0;
    if (marchMode) begin
      case (idx)
        3'd0: begin d.wr = 1'b1; end
        3'd1: begin d.rd = 1'b1; d.wr = 1'b1; d.wrOne = 1'b1; end
        3'd2: begin d.rd = 1'b1; d.wr = 1'b1; d.expOne = 1'b1; end
        3'd3: begin d.rd = 1'b1; d.wr = 1'b1; d.wrOne = 1'b1; d.down = 1'b1; end
        3'd4: begin d.rd = 1'b1; d.wr = 1'b1; d.expOne = 1'b1; d.down = 1'b1; end
        default: begin d.rd = 1'b1; d.last = 1'b1; end
      endcase
    end else begin
      case (idx)
        3'd0: begin d.wr = 1'b1; end
        3'd1: begin d.rd = 1'b1; end
        3'd2: begin d.wr = 1'b1; d.wrOne = 1'b1; end
        default: begin d.rd = 1'b1; d.expOne = 1'b1; d.last = 1'b1; end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeSel,
  output logic              busy,
  output strobe_t           strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic [ELEM_W-1:0] opElem
);

  localparam logic [ADDR_W-1:0] MAX_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] ONE_ADDR = ADDR_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t            state;
  logic              marchMode;
  logic [ELEM_W-1:0] elem;
  logic [ADDR_W-1:0] addr;
  logic              phaseWr;

  elemDesc_t desc, nextDesc;
  logic      accept, running, stepDone, atEnd;

  assign desc     = lookupElem(marchMode, elem);
  assign nextDesc = lookupElem(marchMode, elem + 3'd1);
  assign accept   = (state == S_IDLE) && startReq;
  assign running  = (state == S_RUN);
  assign stepDone = running && (!(desc.rd && desc.wr) || phaseWr);
  assign atEnd    = desc.down ? (addr == '0) : (addr == MAX_ADDR);

  always_comb begin
    strobe          = '0;
    strobe.doRead   = running && desc.rd && !phaseWr;
    strobe.doWrite  = running && desc.wr && (!desc.rd || phaseWr);
    strobe.wrOne    = desc.wrOne;
    strobe.expOne   = desc.expOne;
    strobe.clearLog = accept;
    strobe.finish   = (state == S_DRAIN);
  end

  assign busy   = (state != S_IDLE);
  assign opAddr = addr;
  assign opElem = elem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      marchMode <= 1'b0;
      elem      <= '0;
      addr      <= '0;
      phaseWr   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startReq) begin
            state     <= S_RUN;
            marchMode <= modeSel;
            elem      <= '0;
            addr      <= '0;
            phaseWr   <= 1'b0;
          end
        end
        S_RUN: begin
          if (!stepDone) begin
            phaseWr <= 1'b1;
          end else begin
            phaseWr <= 1'b0;
            if (atEnd) begin
              if (desc.last) begin
                state <= S_DRAIN;
              end else begin
                elem <= elem + 3'd1;
                addr <= nextDesc.down ? MAX_ADDR : '0;
              end
            end else begin
              addr <= desc.down ? addr - ONE_ADDR : addr + ONE_ADDR;
            end
          end
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/march_bist_dpath.sv
module march_bist_dpath
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [ELEM_W-1:0] opElem,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              doneP,
  output logic              passOk,
  output logic              failSticky,
  output logic [ADDR_W-1:0] failAddr,
  output logic [ELEM_W-1:0] failElem,
  output logic [DATA_W-1:0] failData
);

  // Compare stage: expected value and tag follow the read by one cycle
  logic              chkValid;
  logic              chkExpOne;
  logic [ADDR_W-1:0] chkAddr;
  logic [ELEM_W-1:0] chkElem;
  logic              mismatch;

  assign memEn    = strobe.doRead | strobe.doWrite;
  assign memWe    = strobe.doWrite;
  assign memAddr  = opAddr;
  assign memWdata = {DATA_W{strobe.wrOne}};
  assign mismatch = chkValid && (memRdata != {DATA_W{chkExpOne}});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid  <= 1'b0;
      chkExpOne <= 1'b0;
      chkAddr   <= '0;
      chkElem   <= '0;
    end else begin
      chkValid  <= strobe.doRead;
      chkExpOne <= strobe.expOne;
      chkAddr   <= opAddr;
      chkElem   <= opElem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failSticky <= 1'b0;
      failAddr   <= '0;
      failElem   <= '0;
      failData   <= '0;
      passOk     <= 1'b0;
      doneP      <= 1'b0;
    end else begin
      doneP <= strobe.finish;
      if (strobe.clearLog) begin
        failSticky <= 1'b0;
        failAddr   <= '0;
        failElem   <= '0;
        failData   <= '0;
        passOk     <= 1'b0;
      end else begin
        if (mismatch && !failSticky) begin
          failSticky <= 1'b1;
          failAddr   <= chkAddr;
          failElem   <= chkElem;
          failData   <= memRdata;
        end
        if (strobe.finish) begin
          passOk <= !(failSticky || mismatch);
        end
      end
    end
  end

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              modeSel,
  output logic              busy,
  output logic              doneP,
  output logic              passOk,
  output logic              failSticky,
  output logic [ADDR_W-1:0] failAddr,
  output logic [2:0]        failElem,
  output logic [DATA_W-1:0] failData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] opAddr;
  logic [ELEM_W-1:0] opElem;

  march_bist_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .modeSel  (modeSel),
    .busy     (busy),
    .strobe   (strobe),
    .opAddr   (opAddr),
    .opElem   (opElem)
  );

  march_bist_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opAddr     (opAddr),
    .opElem     (opElem),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .doneP      (doneP),
    .passOk     (passOk),
    .failSticky (failSticky),
    .failAddr   (failAddr),
    .failElem   (failElem),
    .failData   (failData)
  );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneP,
  input logic              passOk,
  input logic              failSticky,
  input logic [ADDR_W-1:0] failAddr,
  input logic [2:0]        failElem,
  input logic              memEn,
  input logic              memWe,
  input logic [DATA_W-1:0] memWdata
);

  // R4
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  // R4
  solid_wdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWdata == '0 || memWdata == '1));

  // R1
  op_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (!busy && (passOk == !failSticky)));

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && failSticky) |=> (failSticky && $stable(failAddr) && $stable(failElem)));

  // R8
  run_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || doneP));

endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .doneP      (doneP),
  .passOk     (passOk),
  .failSticky (failSticky),
  .failAddr   (failAddr),
  .failElem   (failElem),
  .memEn      (memEn),
  .memWe      (memWe),
  .memWdata   (memWdata)
);

// File: tb/sim_march_bist.sv
`timescale 1ns/1ps
module sim_march_bist;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN, startReq, modeSel;
  logic              busy, doneP, passOk, failSticky;
  logic [ADDR_W-1:0] failAddr, memAddr;
  logic [2:0]        failElem;
  logic [DATA_W-1:0] failData, memWdata, memRdata;
  logic              memEn, memWe;

  always #5 clk = ~clk;

  march_bist #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel),
    .busy(busy), .doneP(doneP), .passOk(passOk), .failSticky(failSticky),
    .failAddr(failAddr), .failElem(failElem), .failData(failData),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // SRAM model with fault injection: 0 none, 1 stuck-at-1, 2 no-fall, 3 coupling
  int                faultKind = 0;
  int                faultAddr = 0;
  int                faultBit  = 0;
  int                aggAddr   = 0;
  logic              wipe = 1'b0;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              written [DEPTH];
  logic [DATA_W-1:0] nv;

  always @(posedge clk) begin
    if (wipe) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]     <= '0;
        written[i] <= 1'b0;
      end
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) begin
        nv = memWdata;
        if (faultKind == 2 && int'(memAddr) == faultAddr && written[memAddr] &&
            mem[memAddr][faultBit] && !nv[faultBit])
          nv[faultBit] = 1'b1;
        mem[memAddr]     <= nv;
        written[memAddr] <= 1'b1;
        if (faultKind == 3 && int'(memAddr) == aggAddr && !mem[memAddr][faultBit] && nv[faultBit])
          mem[faultAddr][faultBit] <= ~mem[faultAddr][faultBit];
      end else begin
        memRdata <= mem[memAddr] |
                    ((faultKind == 1 && int'(memAddr) == faultAddr) ? DATA_W'(1 << faultBit) : '0);
      end
    end
  end

  // Scoreboard
  typedef struct {
    bit    we;
    int    addr;
    int    data;
    string tag;
  } opItem_t;

  typedef struct {
    bit    pass;
    int    addr;
    int    elem;
    int    data;
    int    cycles;
    string tag;
  } resItem_t;

  opItem_t  opQ[$];
  resItem_t resQ[$];
  int errors = 0;
  int checks = 0;
  int doneCount = 0;
  int busyCnt = 0;
  bit prevDone = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic pushOp(input bit we, input int addr, input bit one, input string tag);
    opItem_t o;
    o.we = we; o.addr = addr; o.data = one ? (1 << DATA_W) - 1 : 0; o.tag = tag;
    opQ.push_back(o);
  endtask

  // Expected operation streams, built from the algorithm descriptions
  task automatic pushScan();
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < DEPTH; a++)
        pushOp((p % 2) == 0, a, p >= 2, "R2");
  endtask

  task automatic pushMarch();
    for (int e = 0; e < 6; e++)
      for (int i = 0; i < DEPTH; i++) begin
        int a;
        a = (e == 3 || e == 4) ? DEPTH - 1 - i : i;
        if (e > 0) pushOp(1'b0, a, 1'b0, "R3");
        if (e < 5) pushOp(1'b1, a, (e % 2) == 1, "R3");
      end
  endtask

  task automatic runTest(input bit mode, input bit expPass, input int eAddr, input int eElem,
                         input int eData, input string tag, input bit poke);
    resItem_t r;
    int target;
    @(negedge clk); wipe = 1'b1;
    @(negedge clk); wipe = 1'b0;
    if (mode) pushMarch(); else pushScan();
    r.pass = expPass; r.addr = eAddr; r.elem = eElem; r.data = eData; r.tag = tag;
    r.cycles = (mode ? 10 * DEPTH : 4 * DEPTH) + 1;
    resQ.push_back(r);
    target = doneCount + 1;
    modeSel = mode; startReq = 1'b1;
    @(negedge clk); startReq = 1'b0; modeSel = ~mode;
    if (poke) begin
      repeat (20) @(negedge clk);
      startReq = 1'b1;  // R8: must be ignored mid-run
      @(negedge clk); startReq = 1'b0;
      repeat (30) @(negedge clk);
      startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
    end
    wait (doneCount >= target);
    @(negedge clk);
    // R7: verdict held after done
    check(passOk == expPass, "R7", "passOk held", passOk, expPass);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevDone) check(!doneP, "R7", "done width", doneP, 0);
      prevDone = doneP;
      if (busy) busyCnt++;
      if (memEn) begin
        if (opQ.size() == 0) begin
          check(0, "R2/R3", "unexpected op", {memWe, memAddr}, 0);
        end else begin
          opItem_t e;
          e = opQ.pop_front();
          check(memWe == e.we && int'(memAddr) == e.addr && (!e.we || int'(memWdata) == e.data),
                e.tag, "op we/addr/data",
                {memWe, memAddr, memWdata}, (int'(e.we) << (ADDR_W + DATA_W)) | (e.addr << DATA_W) | (e.we ? e.data : int'(memWdata)));
        end
      end
      if (doneP) begin
        if (resQ.size() == 0) begin
          check(0, "R7", "unexpected done", 1, 0);
        end else begin
          resItem_t r;
          r = resQ.pop_front();
          check(opQ.size() == 0, r.tag, "ops missing at done", opQ.size(), 0);
          opQ.delete();
          check(busyCnt == r.cycles, "R7", "busy length", busyCnt, r.cycles);
          check(passOk == r.pass, r.tag, "passOk", passOk, r.pass);
          check(failSticky == !r.pass, r.tag, "failSticky", failSticky, !r.pass);
          if (!r.pass) begin
            check(int'(failAddr) == r.addr, r.tag, "failAddr", failAddr, r.addr);
            check(int'(failElem) == r.elem, r.tag, "failElem", failElem, r.elem);
            check(int'(failData) == r.data, r.tag, "failData", failData, r.data);
          end
        end
        busyCnt = 0;
        doneCount++;
      end
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      report();
    end
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; modeSel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !doneP && !memEn && !memWe, "R1", "idle strobes", {busy, doneP, memEn, memWe}, 0);
    check(!passOk && !failSticky, "R1", "verdict flags", {passOk, failSticky}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !memEn && !doneP, "R1", "after release", {busy, memEn, doneP}, 0);

    // R2, R7: clean scan run
    runTest(1'b0, 1'b1, 0, 0, 0, "R2", 1'b0);
    // R3, R7, R8: clean march run with start pulses mid-run
    runTest(1'b1, 1'b1, 0, 0, 0, "R8", 1'b1);

    // R5, R6: stuck-at-1 at address 7 bit 2
    faultKind = 1; faultAddr = 7; faultBit = 2;
    runTest(1'b0, 1'b0, 7, 1, 8'h04, "R5", 1'b0);
    runTest(1'b1, 1'b0, 7, 1, 8'h04, "R6", 1'b0);

    // R9: bit 5 at address 9 cannot fall after its first write
    faultKind = 2; faultAddr = 9; faultBit = 5;
    runTest(1'b0, 1'b1, 0, 0, 0, "R9", 1'b0);
    runTest(1'b1, 1'b0, 9, 3, 8'h20, "R9", 1'b0);

    // R5: rising bit 0 at address 5 inverts bit 0 at address 3
    faultKind = 3; faultAddr = 3; faultBit = 0; aggAddr = 5;
    runTest(1'b1, 1'b0, 3, 2, 8'hFE, "R5", 1'b0);

    // R6: log cleared by the next start
    faultKind = 0;
    runTest(1'b1, 1'b1, 0, 0, 0, "R6", 1'b0);
    runTest(1'b0, 1'b1, 0, 0, 0, "R2", 1'b0);

    report();
  end

endmodule